// File: doc/BRIEF.md
# Relative Branch Cycle Controller

This block runs the tail of a conditional relative branch once the byte after the opcode has been fetched. It advances the program counter past that byte, decides whether the branch is taken, issues the dummy bus reads an 8-bit processor core performs while it forms the target, and produces the new program counter. The target is the advanced program counter plus the byte taken as a signed two's-complement value. When the target falls in a different 256-byte page, one more read cycle is inserted to fix up the high byte. The block also reports how many bus cycles the whole instruction used, counting the opcode and operand fetches.

There are two instruction forms. The plain form tests one flag bit against a wanted value. The bit-test form (present when the `BIT_TEST_EN` parameter is 1) treats the first byte as a zero-page address. It reads that location twice, fetches a second byte as the offset, and branches on one bit of the value it read. The bit number and the polarity come from the opcode. The core pulses `start` with the inputs valid. Reads complete in the same cycle: `rd_data` must reflect `bus_addr` while `bus_rd` is high. `done` pulses for one cycle with `pc_out` and `cycles_used` valid.

States: `ST_IDLE` waits for `start`. `ST_ZP_A` and `ST_ZP_B` are the two zero-page reads of the bit-test form. `ST_OFS` fetches the second offset. `ST_TAKEN` is the dummy read at the advanced counter. `ST_FIX` is the page-fix read. `ST_DONE` presents the result. Transitions:
- `ST_IDLE` goes to `ST_ZP_A` for the bit-test form, to `ST_TAKEN` for a taken plain branch, and to `ST_DONE` otherwise.
- `ST_ZP_A` goes to `ST_ZP_B`, then to `ST_OFS`.
- `ST_OFS` goes to `ST_TAKEN` if the tested bit matches, and to `ST_DONE` otherwise.
- `ST_TAKEN` goes to `ST_FIX` on a page crossing, and to `ST_DONE` otherwise.
- `ST_FIX` goes to `ST_DONE`, and `ST_DONE` goes to `ST_IDLE`.

Top module: `brc_branch_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `bus_rd` are 0, and `pc_out` and `cycles_used` are 0.
- R2: Plain form: the branch is taken when `flags[cond_sel]` equals `cond_val`. A branch that is not taken issues no bus read. `done` rises in the cycle after `start` is sampled, with `pc_out` = `pc_in`+1 and `cycles_used` = 2.
- R3: A taken plain branch issues exactly one read, at `pc_in`+1. When the target keeps the high byte of `pc_in`+1, it ends with `pc_out` = `pc_in`+1+sext(`arg_byte`) and `cycles_used` = 3.
- R4: A taken plain branch whose target high byte differs issues a second read. That read's address has the high byte of `pc_in`+1 and the low byte of the target. `cycles_used` is 4.
- R5: The offset is signed. Values 0x80 to 0xFF move backwards, down to -128, and the 16-bit sum wraps modulo 65536.
- R6: Bit-test form (`bit_mode`=1): the block reads address {0x00,`arg_byte`} twice, then reads the offset at `pc_in`+1. When not taken it ends with `pc_out` = `pc_in`+2 and `cycles_used` = 5.
- R7: Bit-test form: the tested bit index is `opcode[6:4]`. The branch is taken when that bit of the value from the second zero-page read equals `opcode[7]`.
- R8: A taken bit-test branch issues a read at `pc_in`+2 and has `cycles_used` = 6. On a page crossing it issues one more read, again at `pc_in`+2, and has `cycles_used` = 7. Its `pc_out` = `pc_in`+2+sext(offset).
- R9: `start` while `busy` is 1 is ignored: the running branch's reads and result are unchanged.
- R10: `done` is high for exactly one cycle. `busy` is 0 in the cycle after it. `bus_rd` is never high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a branch; sampled only when idle |
| bit_mode | input | 1 | 1 selects the bit-test form |
| pc_in | input | 16 | Address of the byte that followed the opcode |
| arg_byte | input | 8 | That byte: the offset (plain) or the zero-page address (bit-test) |
| opcode | input | 8 | Opcode; bits 6:4 give the bit index and bit 7 the polarity in bit-test form |
| flags | input | 8 | Flag byte for the plain condition |
| cond_sel | input | 3 | Flag bit to test in plain form |
| cond_val | input | 1 | Value that makes the plain branch taken |
| rd_data | input | 8 | Read data for the current bus cycle |
| bus_rd | output | 1 | A read cycle is issued this cycle |
| bus_addr | output | 16 | Address of the read cycle |
| busy | output | 1 | A branch is in progress |
| done | output | 1 | One-cycle pulse: the result is valid |
| pc_out | output | 16 | New program counter |
| cycles_used | output | 3 | Total cycles of the instruction |

## Verification
The bench targets the offsets at the edges of the signed range: +127, -128 and -1. It also uses targets that cross a page forward and backward, and counters that wrap at 0xFFFF. A design that added the offset unsigned, or compared the wrong high bytes, would produce a wrong `pc_out` or skip or add the fix-up read. It checks the address of the fix-up read in both forms, because a design that shared one address rule for both would put the bit-test fix read at the wrong address. All eight tested bit positions are covered with both polarities. A second `start` is injected mid-branch; a design that restarted on it would emit an extra read trace and a second result.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ZP_A  = 3'd1,
        ST_ZP_B  = 3'd2,
        ST_OFS   = 3'd3,
        ST_TAKEN = 3'd4,
        ST_FIX   = 3'd5,
        ST_DONE  = 3'd6
    } brc_state_t;

    // cycles spent on opcode and first operand before the block starts
    localparam int unsigned BRC_BASE_CYCLES = 2;
endpackage

// File: rtl/brc_cond.sv
module brc_cond #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SEL_W       = 3,
    parameter bit          BIT_TEST_EN = 1'b1
) (
    input  logic [DATA_W-1:0] flags,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              cond_val,
    input  logic [DATA_W-1:0] test_value,
    input  logic [7:0]        test_opcode,
    output logic              plain_hit,
    output logic              bit_hit
);
    assign plain_hit = (flags[cond_sel] == cond_val);

    generate
        if (BIT_TEST_EN) begin : g_bit
            logic [2:0] bit_idx;
            logic       want_set;
            logic       unused_opc_low;
            assign bit_idx        = test_opcode[6:4];
            assign want_set       = test_opcode[7];
            assign unused_opc_low = ^test_opcode[3:0];
            assign bit_hit        = (test_value[bit_idx] == want_set);
        end else begin : g_nobit
            logic unused_bit_inputs;
            assign unused_bit_inputs = ^{test_value, test_opcode};
            assign bit_hit           = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] target,
    output logic              crosses
);
    localparam int unsigned EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
    assign target  = base + ofs_ext;
    assign crosses = (target[ADDR_W-1:PAGE_W] != base[ADDR_W-1:PAGE_W]);
endmodule

// File: rtl/brc_branch_ctrl.sv
module brc_branch_ctrl
    import brc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PAGE_W      = 8,
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned CNT_W       = 3,
    parameter bit          BIT_TEST_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_mode,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        arg_byte,
    input  logic [7:0]        opcode,
    input  logic [7:0]        flags,
    input  logic [2:0]        cond_sel,
    input  logic              cond_val,
    input  logic [7:0]        rd_data,
    output logic              bus_rd,
    output logic [15:0]       bus_addr,
    output logic              busy,
    output logic              done,
    output logic [15:0]       pc_out,
    output logic [2:0]        cycles_used
);
    localparam int unsigned HI_W = ADDR_W - PAGE_W;

    brc_state_t state, state_nx;

    logic [ADDR_W-1:0] pc_r;
    logic [ADDR_W-1:0] base_r;
    logic [DATA_W-1:0] off_r;
    logic [DATA_W-1:0] zp_r;
    logic [DATA_W-1:0] opnd_r;
    logic [7:0]        opc_r;
    logic              bitm_r;
    logic [CNT_W-1:0]  cnt_r;

    logic              plain_hit;
    logic              bit_hit;
    logic [ADDR_W-1:0] tgt;
    logic              tgt_cross;
    logic              bit_form_in;
    logic              in_fix;

    assign bit_form_in = bit_mode & BIT_TEST_EN;

    brc_cond #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .BIT_TEST_EN(BIT_TEST_EN)
    ) u_cond (
        .flags      (flags),
        .cond_sel   (cond_sel),
        .cond_val   (cond_val),
        .test_value (opnd_r),
        .test_opcode(opc_r),
        .plain_hit  (plain_hit),
        .bit_hit    (bit_hit)
    );

    brc_target #(
        .ADDR_W(ADDR_W), .OFS_W(DATA_W), .PAGE_W(PAGE_W)
    ) u_target (
        .base   (pc_r),
        .offset (off_r),
        .target (tgt),
        .crosses(tgt_cross)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (bit_form_in)     state_nx = ST_ZP_A;
                    else if (plain_hit)  state_nx = ST_TAKEN;
                    else                 state_nx = ST_DONE;
                end
            end
            ST_ZP_A:  state_nx = ST_ZP_B;
            ST_ZP_B:  state_nx = ST_OFS;
            ST_OFS:   state_nx = bit_hit ? ST_TAKEN : ST_DONE;
            ST_TAKEN: state_nx = tgt_cross ? ST_FIX : ST_DONE;
            ST_FIX:   state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_r   <= '0;
            base_r <= '0;
            off_r  <= '0;
            zp_r   <= '0;
            opnd_r <= '0;
            opc_r  <= '0;
            bitm_r <= 1'b0;
            cnt_r  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc_r   <= pc_in + 1'b1;
                        off_r  <= arg_byte;
                        zp_r   <= arg_byte;
                        opc_r  <= opcode;
                        bitm_r <= bit_form_in;
                        cnt_r  <= CNT_W'(BRC_BASE_CYCLES);
                    end
                end
                ST_ZP_A: cnt_r <= cnt_r + 1'b1;
                ST_ZP_B: begin
                    opnd_r <= rd_data;
                    cnt_r  <= cnt_r + 1'b1;
                end
                ST_OFS: begin
                    off_r <= rd_data;
                    pc_r  <= pc_r + 1'b1;
                    cnt_r <= cnt_r + 1'b1;
                end
                ST_TAKEN: begin
                    base_r <= pc_r;
                    pc_r   <= tgt;
                    cnt_r  <= cnt_r + 1'b1;
                end
                ST_FIX:  cnt_r <= cnt_r + 1'b1;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign in_fix = (state == ST_FIX);

    // outputs
    always_comb begin
        bus_rd   = 1'b0;
        bus_addr = '0;
        busy     = (state != ST_IDLE);
        done     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ZP_A, ST_ZP_B: begin
                bus_rd   = 1'b1;
                bus_addr = {{HI_W{1'b0}}, zp_r};
            end
            ST_OFS, ST_TAKEN: begin
                bus_rd   = 1'b1;
                bus_addr = pc_r;
            end
            ST_FIX: begin
                bus_rd   = 1'b1;
                bus_addr = bitm_r ? base_r
                                  : {base_r[ADDR_W-1:PAGE_W], pc_r[PAGE_W-1:0]};
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign pc_out      = pc_r;
    assign cycles_used = cnt_r;
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        bus_rd,
    input logic [15:0] bus_addr,
    input logic [2:0]  cycles_used,
    input logic        in_fix,
    input logic [7:0]  tgt_high
);
    // R10: no read while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_rd);

    // R10: done is a single-cycle pulse followed by idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2/R8: cycle total within the two forms' range
    a_r2_cycle_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles_used >= 3'd2 && cycles_used <= 3'd7));

    // R4: fix-up read keeps the old page, which differs from the new target page
    a_r4_fix_old_page: assert property (@(posedge clk) disable iff (!rst_n)
        in_fix |-> (bus_rd && bus_addr[15:8] != tgt_high));

    // R4: fix-up read always ends on the result
    a_r4_fix_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        in_fix |=> done);
endmodule

bind brc_branch_ctrl brc_checker u_brc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .cycles_used(cycles_used),
    .in_fix     (in_fix),
    .tgt_high   (pc_r[15:8])
);

// File: tb/tb_brc_branch_ctrl.sv
`timescale 1ns/1ps
module tb_brc_branch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bit_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  arg_byte = '0;
    logic [7:0]  opcode = '0;
    logic [7:0]  flags = '0;
    logic [2:0]  cond_sel = '0;
    logic        cond_val = 1'b0;
    logic [7:0]  rd_data;
    logic        bus_rd;
    logic [15:0] bus_addr;
    logic        busy;
    logic        done;
    logic [15:0] pc_out;
    logic [2:0]  cycles_used;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";

    logic [15:0] addr_q[$];
    logic [18:0] res_q[$];

    logic [15:0] zp_addr_m = 16'hFFFF;
    logic [7:0]  zp_val_m = '0;
    logic [15:0] ofs_addr_m = 16'hFFFF;
    logic [7:0]  ofs_val_m = '0;

    always #4 clk = ~clk;

    assign rd_data = (bus_addr == zp_addr_m)  ? zp_val_m :
                     (bus_addr == ofs_addr_m) ? ofs_val_m : 8'hEE;

    brc_branch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_mode(bit_mode),
        .pc_in(pc_in), .arg_byte(arg_byte), .opcode(opcode), .flags(flags),
        .cond_sel(cond_sel), .cond_val(cond_val), .rd_data(rd_data),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .busy(busy), .done(done),
        .pc_out(pc_out), .cycles_used(cycles_used)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: compare every read and every result against the queues
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (addr_q.size() == 0)
                check(1'b0, cur_tag, "unexpected read", {16'h0, bus_addr}, 32'h0);
            else begin
                logic [15:0] e;
                e = addr_q.pop_front();
                check(bus_addr == e, cur_tag, "read address", {16'h0, bus_addr}, {16'h0, e});
            end
        end
        if (rst_n && done) begin
            if (res_q.size() == 0)
                check(1'b0, cur_tag, "unexpected result", {13'h0, cycles_used, pc_out}, 32'h0);
            else begin
                logic [18:0] e;
                e = res_q.pop_front();
                check({cycles_used, pc_out} == e, cur_tag, "pc/cycles",
                      {13'h0, cycles_used, pc_out}, {13'h0, e});
            end
        end
    end

    function automatic logic [15:0] sext_add(input logic [15:0] b, input logic [7:0] o);
        return b + {{8{o[7]}}, o};
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        check(addr_q.size() == 0 && res_q.size() == 0, cur_tag, "queues drained",
              addr_q.size(), 0);
    endtask

    task automatic run_plain(input string tag, input logic [15:0] pc, input logic [7:0] ofs,
                             input logic [7:0] flg, input logic [2:0] sel, input logic val);
        logic [15:0] p1, t;
        logic [2:0]  cyc;
        cur_tag = tag;
        p1 = pc + 16'd1;
        if (flg[sel] == val) begin
            addr_q.push_back(p1);
            t = sext_add(p1, ofs);
            cyc = 3'd3;
            if (t[15:8] != p1[15:8]) begin
                addr_q.push_back({p1[15:8], t[7:0]});
                cyc = 3'd4;
            end
        end else begin
            t = p1;
            cyc = 3'd2;
        end
        res_q.push_back({cyc, t});
        bit_mode = 1'b0; pc_in = pc; arg_byte = ofs; flags = flg;
        cond_sel = sel; cond_val = val; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check(addr_q.size() == 0 && res_q.size() == 0, tag, "queues drained",
              addr_q.size() + res_q.size(), 0);
    endtask

    task automatic run_bit(input string tag, input logic [15:0] pc, input logic [7:0] zp,
                           input logic [7:0] opc, input logic [7:0] zval,
                           input logic [7:0] ofs, input bit poke);
        logic [15:0] p1, p2, t;
        logic [2:0]  cyc;
        cur_tag = tag;
        p1 = pc + 16'd1;
        p2 = pc + 16'd2;
        addr_q.push_back({8'h00, zp});
        addr_q.push_back({8'h00, zp});
        addr_q.push_back(p1);
        if (zval[opc[6:4]] == opc[7]) begin
            addr_q.push_back(p2);
            t = sext_add(p2, ofs);
            cyc = 3'd6;
            if (t[15:8] != p2[15:8]) begin
                addr_q.push_back(p2);
                cyc = 3'd7;
            end
        end else begin
            t = p2;
            cyc = 3'd5;
        end
        res_q.push_back({cyc, t});
        zp_addr_m = {8'h00, zp}; zp_val_m = zval;
        ofs_addr_m = p1; ofs_val_m = ofs;
        bit_mode = 1'b1; pc_in = pc; arg_byte = zp; opcode = opc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R9: a second start mid-branch with different inputs
            @(negedge clk);
            check(busy == 1'b1, "R9", "busy mid-branch", busy, 1);
            bit_mode = 1'b0; pc_in = 16'h1234; arg_byte = 8'h40;
            flags = 8'hFF; cond_sel = 3'd0; cond_val = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(addr_q.size() == 0 && res_q.size() == 0, tag, "queues drained",
              addr_q.size() + res_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1", "busy", busy, 0);
        check(done == 0, "R1", "done", done, 0);
        check(bus_rd == 0, "R1", "bus_rd", bus_rd, 0);
        check(pc_out == 0, "R1", "pc_out", pc_out, 0);
        check(cycles_used == 0, "R1", "cycles", cycles_used, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 not taken, both polarities
        run_plain("R2", 16'h2000, 8'h10, 8'b0000_0001, 3'd0, 1'b0);
        run_plain("R2", 16'h2100, 8'h10, 8'b1111_1011, 3'd2, 1'b1);
        // R3 taken, same page
        run_plain("R3", 16'h3010, 8'h20, 8'b1000_0000, 3'd7, 1'b1);
        run_plain("R3", 16'h3050, 8'hF0, 8'b0000_0000, 3'd5, 1'b0);
        // R4 page crossing forward and backward
        run_plain("R4", 16'h30F0, 8'h20, 8'b0000_0010, 3'd1, 1'b1);
        run_plain("R4", 16'h3005, 8'hE0, 8'b0000_0000, 3'd6, 1'b0);
        // R5 signed extremes and wrap
        run_plain("R5", 16'h4000, 8'h7F, 8'b0000_1000, 3'd3, 1'b1);
        run_plain("R5", 16'h4000, 8'h80, 8'b0000_1000, 3'd3, 1'b1);
        run_plain("R5", 16'h40FE, 8'hFF, 8'b0001_0000, 3'd4, 1'b1);
        run_plain("R5", 16'hFFF0, 8'h20, 8'b0000_0100, 3'd2, 1'b1);
        run_plain("R5", 16'hFFFF, 8'h05, 8'b0000_0100, 3'd2, 1'b1);

        // R6 bit-test not taken; R7 every bit, both polarities
        run_bit("R6", 16'h5000, 8'h44, 8'h0F, 8'h01, 8'h10, 1'b0);
        for (int b = 0; b < 8; b++) begin
            run_bit("R7", 16'h5100, 8'h30 + 8'(b), {1'b1, 3'(b), 4'hF},
                    8'(1 << b), 8'h08, 1'b0);
            run_bit("R7", 16'h5200, 8'h50 + 8'(b), {1'b0, 3'(b), 4'hF},
                    ~8'(1 << b), 8'h08, 1'b0);
            run_bit("R7", 16'h5300, 8'h70 + 8'(b), {1'b1, 3'(b), 4'hF},
                    ~8'(1 << b), 8'h08, 1'b0);
        end
        // R8 taken same page and page crossing
        run_bit("R8", 16'h6010, 8'h22, 8'hAF, 8'h04, 8'h30, 1'b0);
        run_bit("R8", 16'h60F0, 8'h22, 8'hAF, 8'h04, 8'h40, 1'b0);
        run_bit("R8", 16'h6002, 8'h22, 8'h2F, 8'h00, 8'h80, 1'b0);

        // R9 start while busy ignored
        run_bit("R9", 16'h70FA, 8'h66, 8'h9F, 8'h02, 8'h30, 1'b1);
        @(negedge clk);
        check(pc_out == 16'h712C, "R9", "pc_out held", pc_out, 16'h712C);

        // R10 idle after done, no stray activity
        repeat (3) begin
            @(negedge clk);
            check(!busy && !done && !bus_rd, "R10", "idle quiet",
                  {busy, done, bus_rd}, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule